// File: doc/BRIEF.md
# Flag Offset Programmer

This block holds the four offset values (X1, Y1, X2, Y2) that the almost-full and almost-empty comparators of a two-FIFO pair compare against. Each value is `OFS_W = log2(DEPTH)` bits wide. It supports three loading methods, and the method is fixed while master reset is held low.

In **preset** mode all four offsets take one of three constants (8, 16 or 64). In **parallel** mode the offsets are written one at a time from the port A data bus through a valid/ready handshake. In **serial** mode they are shifted in one bit per clock over two pins. In serial mode these are the same two pins that chose the preset value during reset. A single `done` output tells the surrounding FIFO logic that its thresholds are settled.

Back-pressure on the parallel write channel works as follows. A word is taken only on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` depends only on the mode, the reset pins and `done`, and never on `wr_valid`. A source may therefore hold `wr_valid` high for as long as it likes, and nothing is lost or repeated. Partial reset `prst_n` stalls all loading but keeps everything already loaded.

Top module: `fop_offset_prog`

## Requirements
- R1: At every rising `clk` edge with `mrst_n` low, the mode is captured from `spm` and sel = {`msel1_sen_n`,`msel0_sdi`}. The decoding is: `spm`=0 selects serial; `spm`=1 with sel=00 selects parallel; sel=01, 10 and 11 select presets of 8, 16 and 64. The value captured at the last such edge applies after release.
- R2: After a rising edge with `mrst_n` low, all four offsets read 0 and `done` reads 0.
- R3: In preset mode, the first edge after release with `prst_n` high loads all four offsets with the preset value and sets `done`.
- R4: In serial mode, each edge with `msel1_sen_n` low shifts `msel0_sdi` into a chain ordered {Y1,X1,Y2,X2}, entering at X2 bit 0. After 4·OFS_W bits, the first bit sits in the MSB of Y1, the last bit sits in the LSB of X2, and `done` rises.
- R5: In serial mode, an edge with `msel1_sen_n` high leaves every offset unchanged.
- R6: In parallel mode, `wr_ready` is high while both resets are high and `done` is low. Each accepted word writes `wr_data[OFS_W-1:0]` into Y1, X1, Y2 and X2, in that order. `done` rises with the fourth word.
- R7: A `wr_valid` outside parallel mode, and serial-enable pulses outside serial mode, change no offset.
- R8: Once `done` is high, serial pulses and write attempts are ignored, and the offsets stay stable until the next master reset.
- R9: While `prst_n` is low, `wr_ready` is low and no load of any kind takes place. Offsets, `done` and load progress are all kept.
- R10: `done` stays high until a master reset clears it. A new master reset can then select a different mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A clock |
| mrst_n | input | 1 | Master reset, active low, sampled on `clk` |
| prst_n | input | 1 | Partial reset, active low; stalls loading |
| spm | input | 1 | Serial-mode select, low = serial |
| msel1_sen_n | input | 1 | Select bit 1 during reset; serial enable (active low) afterwards |
| msel0_sdi | input | 1 | Select bit 0 during reset; serial data afterwards |
| wr_valid | input | 1 | Parallel write word present |
| wr_ready | output | 1 | Parallel word will be accepted this edge |
| wr_data | input | DATA_W | Port A data bus, low OFS_W bits used |
| y1 | output | OFS_W | Offset Y1 |
| x1 | output | OFS_W | Offset X1 |
| y2 | output | OFS_W | Offset Y2 |
| x2 | output | OFS_W | Offset X2 |
| done | output | 1 | Programming complete |

## Verification
Several properties are checked by assertions on every cycle:
- each serial shift moves the chain by one place and lands the sampled data bit at X2 bit 0;
- an idle serial enable, a low partial reset, or a high `done` all freeze the offsets;
- `done` is sticky;
- `wr_ready` never coexists with `done` or with partial reset;
- master reset clears the offsets and `done`.

Other behaviours can only be shown by the bench's scenarios, which run through every preset code, several serial bit patterns (with the chain checked after each bit), and parallel loads with junk in the upper bus bits. These are: mode decoding at release, the mapping from bit order or write order to named registers, the exact bit or word on which `done` rises, and that stimulus aimed at the wrong mode has no effect.

// File: rtl/fop_pkg.sv
package fop_pkg;

  typedef enum logic [1:0] {
    FOP_SERIAL   = 2'd0,
    FOP_PARALLEL = 2'd1,
    FOP_PRESET   = 2'd2
  } fop_mode_e;

  typedef struct packed {
    fop_mode_e  mode;
    logic [1:0] pre_sel;
  } fop_cfg_t;

  // Mode decode from the select pins seen during master reset.
  function automatic fop_cfg_t fop_decode(input logic spm, input logic [1:0] sel);
    fop_cfg_t c;
    c.pre_sel = sel;
    if (!spm)            c.mode = FOP_SERIAL;
    else if (sel == 2'b00) c.mode = FOP_PARALLEL;
    else                 c.mode = FOP_PRESET;
    return c;
  endfunction

  // Preset constants per select code.
  function automatic int unsigned fop_preset(input logic [1:0] sel);
    case (sel)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/fop_mode_latch.sv
module fop_mode_latch
  import fop_pkg::*;
(
  input  logic     clk,
  input  logic     mrst_n,
  input  logic     spm,
  input  logic     sel1,
  input  logic     sel0,
  input  logic     preset_ack,
  output fop_cfg_t cfg,
  output logic     preset_due
);

  fop_cfg_t cfg_q;
  logic     due_q;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cfg_q <= fop_decode(spm, {sel1, sel0});
      due_q <= 1'b1;
    end else if (preset_ack) begin
      due_q <= 1'b0;
    end
  end

  assign cfg        = cfg_q;
  assign preset_due = due_q;

endmodule

// File: rtl/fop_progress.sv
module fop_progress #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic [CNT_W-1:0] limit,
  input  logic             step,
  input  logic             force_done,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (force_done) begin
      done_q <= 1'b1;
    end else if (step && !done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == limit - 1'b1) done_q <= 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign done = done_q;

endmodule

// File: rtl/fop_bank.sv
module fop_bank #(
  parameter int OFS_W = 8,
  localparam int NREG  = 4,
  localparam int CH_W  = NREG * OFS_W
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  input  logic             wr_en,
  input  logic [1:0]       wr_slot,
  input  logic [OFS_W-1:0] wr_word,
  input  logic             fill_en,
  input  logic [OFS_W-1:0] fill_word,
  output logic [CH_W-1:0]  chain
);

  // Slot k (0=Y1,1=X1,2=Y2,3=X2) occupies bits [(NREG-k)*OFS_W-1 -: OFS_W].
  logic [CH_W-1:0] chain_q;
  logic [CH_W-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[CH_W-2:0], shift_bit};
    for (int k = 0; k < NREG; k++) begin
      if (wr_en && (wr_slot == 2'(k)))
        chain_d[(NREG-k)*OFS_W-1 -: OFS_W] = wr_word;
      if (fill_en)
        chain_d[(NREG-k)*OFS_W-1 -: OFS_W] = fill_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign chain = chain_q;

endmodule

// File: rtl/fop_offset_prog.sv
module fop_offset_prog
  import fop_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 36,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int CH_W  = 4 * OFS_W,
  localparam int CNT_W = $clog2(CH_W + 1)
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              spm,
  input  logic              msel1_sen_n,
  input  logic              msel0_sdi,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  y1,
  output logic [OFS_W-1:0]  x1,
  output logic [OFS_W-1:0]  y2,
  output logic [OFS_W-1:0]  x2,
  output logic              done
);

  fop_cfg_t         cfg;
  logic             preset_due;
  logic             active;
  logic             ser_mode;
  logic             ser_step;
  logic             par_step;
  logic             fill;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  chain;
  logic [OFS_W-1:0] fill_word;
  logic             unused_bits;

  fop_mode_latch u_mode (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .spm        (spm),
    .sel1       (msel1_sen_n),
    .sel0       (msel0_sdi),
    .preset_ack (fill),
    .cfg        (cfg),
    .preset_due (preset_due)
  );

  assign active    = mrst_n && prst_n;
  assign ser_mode  = (cfg.mode == FOP_SERIAL);
  assign ser_step  = active && ser_mode && !done && !msel1_sen_n;
  assign wr_ready  = active && (cfg.mode == FOP_PARALLEL) && !done;
  assign par_step  = wr_valid && wr_ready;
  assign fill      = active && (cfg.mode == FOP_PRESET) && preset_due;
  assign limit     = ser_mode ? CNT_W'(CH_W) : CNT_W'(4);
  assign fill_word = OFS_W'(fop_preset(cfg.pre_sel));

  fop_progress #(.CNT_W(CNT_W)) u_prog (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .limit      (limit),
    .step       (ser_step || par_step),
    .force_done (fill),
    .cnt        (cnt),
    .done       (done)
  );

  fop_bank #(.OFS_W(OFS_W)) u_bank (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .shift_en  (ser_step),
    .shift_bit (msel0_sdi),
    .wr_en     (par_step),
    .wr_slot   (cnt[1:0]),
    .wr_word   (wr_data[OFS_W-1:0]),
    .fill_en   (fill),
    .fill_word (fill_word),
    .chain     (chain)
  );

  assign {y1, x1, y2, x2} = chain;
  assign unused_bits = ^{wr_data[DATA_W-1:OFS_W], cnt[CNT_W-1:2]};

endmodule

// File: rtl/fop_checker.sv
module fop_checker #(
  parameter int CH_W = 32
) (
  input logic            clk,
  input logic            mrst_n,
  input logic            prst_n,
  input logic            sen_n,
  input logic            sdi,
  input logic            wr_ready,
  input logic            ser_mode,
  input logic            done,
  input logic [CH_W-1:0] chain
);

  p_clear_r2: assert property (@(posedge clk)
    !mrst_n |=> (chain == '0 && !done));

  p_shift_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_mode && !done && prst_n && !sen_n) |=>
      (chain[0] == $past(sdi) && chain[CH_W-1:1] == $past(chain[CH_W-2:0])));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_mode && sen_n) |=> $stable(chain));

  p_ready_not_done_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    wr_ready |-> !done);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    done |=> $stable(chain));

  p_prst_hold_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(chain) && $stable(done)));

  p_prst_no_ready_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |-> !wr_ready);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!mrst_n)
    done |=> done);

endmodule

bind fop_offset_prog fop_checker #(.CH_W(CH_W)) u_chk (
  .clk      (clk),
  .mrst_n   (mrst_n),
  .prst_n   (prst_n),
  .sen_n    (msel1_sen_n),
  .sdi      (msel0_sdi),
  .wr_ready (wr_ready),
  .ser_mode (ser_mode),
  .done     (done),
  .chain    (chain)
);

// File: tb/sim_fop_offset_prog.sv
module sim_fop_offset_prog;
  localparam int DEPTH = 256;
  localparam int DW    = 36;
  localparam int W     = 8;
  localparam int CW    = 32;

  logic          clk = 1'b0;
  logic          mrst_n = 1'b0, prst_n = 1'b1, spm = 1'b1;
  logic          sen_n = 1'b1, sdi = 1'b0, wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, done;
  logic [W-1:0]  y1, x1, y2, x2;
  int            checks = 0, fails = 0;

  fop_offset_prog #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .spm(spm),
    .msel1_sen_n(sen_n), .msel0_sdi(sdi), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data),
    .y1(y1), .x1(x1), .y2(y2), .x2(x2), .done(done)
  );

  always #5 clk = ~clk;

  wire [CW-1:0] offs = {y1, x1, y2, x2};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Hold master reset with the given mode pins, then release.
  task automatic mreset(input logic spm_v, input logic [1:0] sel_v);
    mrst_n = 1'b0; spm = spm_v; {sen_n, sdi} = sel_v; wr_valid = 1'b0;
    repeat (3) tick();
    chk("R2 offsets cleared", 64'(offs), 64'h0);
    chk("R2 done cleared", 64'(done), 64'h0);
    mrst_n = 1'b1; sen_n = 1'b1; sdi = 1'b0;
    tick();
  endtask

  task automatic serial_run(input logic [CW-1:0] p);
    logic [63:0] e;
    mreset(1'b0, 2'b11);  // sel ignored with spm low
    chk("R1 serial mode: no ready", 64'(wr_ready), 64'h0);
    wr_valid = 1'b1; wr_data = '1; tick(); wr_valid = 1'b0;
    chk("R7 write in serial mode ignored", 64'(offs), 64'h0);
    for (int k = 1; k <= CW; k++) begin
      sen_n = 1'b0; sdi = p[CW-k]; tick();
      e = {32'h0, p} >> (CW - k);
      chk("R4 chain after bit", 64'(offs), e);
      chk("R4 done timing", 64'(done), 64'(k == CW));
      if (k % 3 == 0 && k < CW) begin
        sen_n = 1'b1; sdi = ~sdi; tick();
        chk("R5 idle enable holds", 64'(offs), e);
      end
      if (k == CW / 2) begin
        prst_n = 1'b0; sen_n = 1'b0; sdi = 1'b1;
        repeat (2) tick();
        chk("R9 partial reset holds chain", 64'(offs), e);
        chk("R9 partial reset holds done", 64'(done), 64'h0);
        prst_n = 1'b1; sen_n = 1'b1;
      end
    end
    chk("R4 Y1 holds first byte", 64'(y1), 64'(p[31:24]));
    chk("R4 X2 holds last byte", 64'(x2), 64'(p[7:0]));
    for (int j = 0; j < 5; j++) begin
      sen_n = 1'b0; sdi = ~p[j]; tick();
    end
    sen_n = 1'b1;
    chk("R8 extra serial pulses ignored", 64'(offs), 64'(p));
    chk("R10 done sticky", 64'(done), 64'h1);
  endtask

  task automatic parallel_run(input logic [W-1:0] v0, v1, v2, v3);
    logic [W-1:0] v [4];
    v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3;
    mreset(1'b1, 2'b00);
    chk("R1 parallel mode ready", 64'(wr_ready), 64'h1);
    chk("R6 not done before writes", 64'(done), 64'h0);
    sen_n = 1'b0; sdi = 1'b1; repeat (3) tick(); sen_n = 1'b1;
    chk("R7 serial pulses in parallel mode ignored", 64'(offs), 64'h0);
    for (int i = 0; i < 4; i++) begin
      if (i == 2) begin
        prst_n = 1'b0; wr_valid = 1'b1; wr_data = {28'hFFFFFFF, 8'hEE};
        #1 chk("R9 ready low in partial reset", 64'(wr_ready), 64'h0);
        tick();
        chk("R9 no write in partial reset", 64'(offs), 64'({v[0], v[1], 16'h0}));
        prst_n = 1'b1; wr_valid = 1'b0;
      end
      wr_valid = 1'b1; wr_data = {28'(32'hDEAD_BEEF * (i + 1)), v[i]};
      tick();
      wr_valid = 1'b0; tick();
      chk("R6 done after word", 64'(done), 64'(i == 3));
    end
    chk("R6 Y1", 64'(y1), 64'(v0));
    chk("R6 X1", 64'(x1), 64'(v1));
    chk("R6 Y2", 64'(y2), 64'(v2));
    chk("R6 X2", 64'(x2), 64'(v3));
    chk("R8 ready low after done", 64'(wr_ready), 64'h0);
    wr_valid = 1'b1; wr_data = '0; repeat (2) tick(); wr_valid = 1'b0;
    chk("R8 late writes ignored", 64'(offs), 64'({v0, v1, v2, v3}));
  endtask

  initial begin
    repeat (3) tick();
    chk("R2 reset state offsets", 64'(offs), 64'h0);
    chk("R2 reset state done", 64'(done), 64'h0);

    for (int s = 1; s < 4; s++) begin
      logic [W-1:0] pv;
      pv = (s == 1) ? 8'd8 : (s == 2) ? 8'd16 : 8'd64;
      mreset(1'b1, 2'(s));
      chk("R3 preset Y1", 64'(y1), 64'(pv));
      chk("R3 preset X1", 64'(x1), 64'(pv));
      chk("R3 preset Y2", 64'(y2), 64'(pv));
      chk("R1 preset X2", 64'(x2), 64'(pv));
      chk("R3 preset done", 64'(done), 64'h1);
      chk("R1 preset mode no ready", 64'(wr_ready), 64'h0);
    end

    prst_n = 1'b0;
    mreset(1'b1, 2'b10);
    tick();
    chk("R9 preset waits for partial reset", 64'(offs), 64'h0);
    chk("R9 done waits", 64'(done), 64'h0);
    prst_n = 1'b1; tick();
    chk("R9 preset after partial reset", 64'(offs), 64'h10101010);

    serial_run(32'hA5C3_0F96);
    chk("R10 master reset then new mode", 64'(done), 64'h1);
    serial_run(32'hFFFF_FFFF);
    serial_run(32'h0000_0001);
    serial_run(32'h8000_0000);

    parallel_run(8'h12, 8'hFF, 8'h00, 8'h81);
    parallel_run(8'h7E, 8'h01, 8'hC4, 8'h3B);

    mreset(1'b0, 2'b00);
    chk("R10 done cleared by new master reset", 64'(done), 64'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule